// File: doc/BRIEF.md
# Event-Driven Single-Item Transfer Bank

This block sits beside a processor core and serves interrupt-style events without diverting program flow. It holds eight channels. A trigger on a channel moves one data item between two memory addresses over a plain request/ready memory port. The move is one read followed by one write. After the move the channel advances one of its two pointers and counts the event down. When the count runs out, the next trigger is handed on to the regular interrupt controller as a one-cycle forwarded pulse.

Each channel holds a source pointer, a destination pointer, an 8-bit item count and a 3-bit mode word. The mode word selects byte or word size, which pointer advances, and a continuous mode that never counts down. A programming port writes these registers and reads them back. When several channels are pending, the lowest-numbered one is served first and the others keep their pending state until their turn.

Top module: `evtx_bank`

## Requirements
- R1: After reset every channel register reads zero, `mem_req` is low and no `irq_fwd` bit is set.
- R2: A programming write with `cfg_sel` 0 sets the source pointer, 1 the destination pointer, 2 the count (low 8 bits) and 3 the mode (bit 0 word size, bit 1 advance destination instead of source, bit 2 continuous). `cfg_rdata` returns the register chosen by `cfg_ch`/`cfg_sel`, zero-extended.
- R3: A trigger on a channel whose count is non-zero, or that is in continuous mode, produces exactly one read of the source pointer and then one write to the destination pointer. The write carries the data that was read, and `mem_word` equals mode bit 0 in both accesses.
- R4: In byte mode the written data is the read data with every bit above bit 7 cleared. In word mode it is unchanged.
- R5: When the write completes, the pointer chosen by mode bit 1 advances by 1 in byte mode or by 2 in word mode, wrapping modulo 2^16. The other pointer is unchanged.
- R6: Each completed transfer lowers the count by one unless the channel is in continuous mode. In continuous mode the count is unchanged.
- R7: A transfer that brings the count to zero causes exactly one single-cycle pulse on that channel's `irq_fwd` bit, in the cycle after the write is accepted.
- R8: A trigger on a channel whose count is zero and that is not in continuous mode makes no memory access and gives one `irq_fwd` pulse for that channel.
- R9: Among pending channels the lowest-numbered is served first. Triggers that arrive during a transfer stay pending and are served later.
- R10: While `mem_rdy` is low, the request, address and direction are held. The pointers and the count do not change until the write is accepted.
- R11: A transfer in continuous mode never raises `irq_fwd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 8 | One-cycle event pulse per channel |
| cfg_we | input | 1 | Programming write strobe |
| cfg_ch | input | 3 | Channel selected for programming and readback |
| cfg_sel | input | 2 | Register selected (0 src, 1 dst, 2 count, 3 mode) |
| cfg_wdata | input | 16 | Programming write data |
| cfg_rdata | output | 16 | Readback of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_rdy | input | 1 | Access completes on a clock edge where this is high |
| irq_fwd | output | 8 | One-cycle forwarded interrupt per channel |

## Verification
Single triggers on one channel run its count through 3, 2, 1 and then 0. This separates the last real transfer, which must raise the pulse, from the trigger that follows it, which must be forwarded with no bus access. Word-size channels whose destination pointer sits just below the top of the address space show both the step size and the wrap. A continuous-mode channel programmed with count zero tells continuous mode apart from exhaustion. An all-channel burst, a late trigger during a transfer, and seeded random configurations run with a randomly stalling ready line. They show that service order depends only on channel number and that nothing is updated before the write completes.

// File: rtl/evtx_pkg.sv
package evtx_pkg;
  typedef struct packed {
    logic cont;
    logic dst_inc;
    logic word;
  } mode_t;

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  // Pointer advance per item: one byte or one two-byte word.
  function automatic logic [1:0] ptr_step(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/evtx_pick.sv
module evtx_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/evtx_chan.sv
module evtx_chan
  import evtx_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          take,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          done,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output mode_t         mode,
  output logic          pend
);
  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p, input logic word);
    return p + {{(AW-2){1'b0}}, ptr_step(word)};
  endfunction

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
      mode <= '0;
      pend <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_SRC:  src  <= wr_data;
          SEL_DST:  dst  <= wr_data;
          SEL_CNT:  cnt  <= wr_data[CW-1:0];
          default:  mode <= mode_t'(wr_data[2:0]);
        endcase
      end else if (done) begin
        if (mode.dst_inc) dst <= advance(dst, mode.word);
        else              src <= advance(src, mode.word);
        if (!mode.cont)   cnt <= count_down(cnt);
      end
      pend <= trig | (pend & ~take);
    end
  end

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_en && !mode.cont |=> cnt == $past(cnt) - CW'(1));

  // R6
  cont_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !wr_en && mode.cont |=> $stable(cnt));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !wr_en |=> $stable(src) && $stable(dst) && $stable(cnt));

  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !take |=> pend);
endmodule

// File: rtl/evtx_engine.sv
module evtx_engine
  import evtx_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          pend,
  input  logic [NCH-1:0][AW-1:0]  src_all,
  input  logic [NCH-1:0][AW-1:0]  dst_all,
  input  logic [NCH-1:0][CW-1:0]  cnt_all,
  input  mode_t [NCH-1:0]         mode_all,
  output logic [NCH-1:0]          take,
  output logic [NCH-1:0]          done,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_word,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  input  logic                    mem_rdy,
  output logic [NCH-1:0]          irq_fwd
);
  function automatic logic [DW-1:0] size_fit(input logic [DW-1:0] d, input logic word);
    return word ? d : {{(DW-8){1'b0}}, d[7:0]};
  endfunction

  function automatic logic is_last(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  function automatic logic is_spent(input logic [CW-1:0] c, input mode_t m);
    return (c == '0) && !m.cont;
  endfunction

  phase_t         phase, phase_nx;
  logic [IW-1:0]  cur;
  logic [IW-1:0]  pick;
  logic           pick_any;
  logic [DW-1:0]  hold;
  logic [NCH-1:0] irq_d;
  mode_t          cur_mode;

  evtx_pick #(.N(NCH)) u_pick (
    .req (pend),
    .idx (pick),
    .any (pick_any)
  );

  assign cur_mode = mode_all[cur];

  always_comb begin
    phase_nx = phase;
    take     = '0;
    done     = '0;
    irq_d    = '0;
    case (phase)
      PH_IDLE: begin
        if (pick_any) begin
          take[pick] = 1'b1;
          if (is_spent(cnt_all[pick], mode_all[pick])) irq_d[pick] = 1'b1;
          else                                         phase_nx    = PH_READ;
        end
      end
      PH_READ: begin
        if (mem_rdy) phase_nx = PH_WRITE;
      end
      default: begin
        if (mem_rdy) begin
          done[cur] = 1'b1;
          if (!cur_mode.cont && is_last(cnt_all[cur])) irq_d[cur] = 1'b1;
          phase_nx = PH_IDLE;
        end
      end
    endcase
  end

  assign mem_req   = (phase != PH_IDLE);
  assign mem_we    = (phase == PH_WRITE);
  assign mem_word  = cur_mode.word;
  assign mem_addr  = (phase == PH_WRITE) ? dst_all[cur] : src_all[cur];
  assign mem_wdata = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cur     <= '0;
      hold    <= '0;
      irq_fwd <= '0;
    end else begin
      phase   <= phase_nx;
      irq_fwd <= irq_d;
      if (phase == PH_IDLE && phase_nx == PH_READ) cur <= pick;
      if (phase == PH_READ && mem_rdy) hold <= size_fit(mem_rdata, cur_mode.word);
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_rdy |=> mem_req && mem_we && $stable(mem_word));

  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) |-> $onehot0(take) && ((pend & (take - NCH'(1))) == '0));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_fwd));

  // R8
  no_bus_on_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) && (irq_d != '0) |=> !mem_req);
endmodule

// File: rtl/evtx_bank.sv
module evtx_bank
  import evtx_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  cfg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_word,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_rdy,
  output logic [NCH-1:0] irq_fwd
);
  logic [NCH-1:0][AW-1:0] src_all;
  logic [NCH-1:0][AW-1:0] dst_all;
  logic [NCH-1:0][CW-1:0] cnt_all;
  mode_t [NCH-1:0]        mode_all;
  logic [NCH-1:0]         pend;
  logic [NCH-1:0]         take;
  logic [NCH-1:0]         done;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    evtx_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig[i]),
      .take    (take[i]),
      .wr_en   (cfg_we && (cfg_ch == IW'(i))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .done    (done[i]),
      .src     (src_all[i]),
      .dst     (dst_all[i]),
      .cnt     (cnt_all[i]),
      .mode    (mode_all[i]),
      .pend    (pend[i])
    );
  end

  evtx_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .src_all   (src_all),
    .dst_all   (dst_all),
    .cnt_all   (cnt_all),
    .mode_all  (mode_all),
    .take      (take),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_word  (mem_word),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_rdy   (mem_rdy),
    .irq_fwd   (irq_fwd)
  );

  always_comb begin
    case (cfg_sel)
      SEL_SRC: cfg_rdata = src_all[cfg_ch];
      SEL_DST: cfg_rdata = dst_all[cfg_ch];
      SEL_CNT: cfg_rdata = {{(AW-CW){1'b0}}, cnt_all[cfg_ch]};
      default: cfg_rdata = {{(AW-3){1'b0}}, mode_all[cfg_ch]};
    endcase
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !mem_req && (irq_fwd == '0));
endmodule

// File: tb/sim_evtx_bank.sv
module sim_evtx_bank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        mem_req, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rdy = 1'b1;
  logic [7:0]  irq_fwd;

  evtx_bank u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .irq_fwd(irq_fwd)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_src [8];
  logic [15:0] m_dst [8];
  logic [7:0]  m_cnt [8];
  logic [2:0]  m_mode[8];
  int          exp_irq[8];
  int          got_irq[8];
  int          order_q[$];
  logic [15:0] cap = '0;
  logic [15:0] prev_addr = '0;
  bit          prev_stall = 0;
  bit          stall_on = 0;
  int          mon_c;

  function automatic logic [15:0] f_step(input logic [2:0] md);
    return md[0] ? 16'd2 : 16'd1;
  endfunction

  function automatic logic [15:0] f_fit(input logic [2:0] md, input logic [15:0] d);
    return md[0] ? d : (d & 16'h00ff);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory side: ready and read data change away from the clock edge
  always @(posedge clk) begin
    #2;
    mem_rdy   = stall_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    mem_rdata = 16'($urandom);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 8; c++) if (irq_fwd[c]) got_irq[c]++;
      if (prev_stall)
        chk(mem_req && mem_addr == prev_addr, "R10", "held address", mem_addr, prev_addr);
      if (mem_req && mem_rdy) begin
        if (order_q.size() == 0) begin
          chk(0, "R8", "unexpected access", mem_addr, 0);
        end else begin
          mon_c = order_q[0];
          if (!mem_we) begin
            chk(mem_addr == m_src[mon_c], "R3", "read address", mem_addr, m_src[mon_c]);
            chk(mem_word == m_mode[mon_c][0], "R3", "read size", mem_word, m_mode[mon_c][0]);
            cap = f_fit(m_mode[mon_c], mem_rdata);
          end else begin
            chk(mem_addr == m_dst[mon_c], "R3", "write address", mem_addr, m_dst[mon_c]);
            chk(mem_wdata == cap, "R4", "write data", mem_wdata, cap);
            if (m_mode[mon_c][1]) m_dst[mon_c] = m_dst[mon_c] + f_step(m_mode[mon_c]);
            else                  m_src[mon_c] = m_src[mon_c] + f_step(m_mode[mon_c]);
            if (!m_mode[mon_c][2]) begin
              m_cnt[mon_c] = m_cnt[mon_c] - 8'd1;
              if (m_cnt[mon_c] == 0) exp_irq[mon_c]++;
            end
            void'(order_q.pop_front());
          end
        end
      end
      prev_stall = mem_req && !mem_rdy;
      prev_addr  = mem_addr;
    end
  end

  task automatic cfg_write(input int ch, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] s, input logic [15:0] d,
                      input logic [7:0] n, input logic [2:0] md);
    cfg_write(ch, 2'd0, s);
    cfg_write(ch, 2'd1, d);
    cfg_write(ch, 2'd2, {8'h00, n});
    cfg_write(ch, 2'd3, {13'h0, md});
    m_src[ch] = s; m_dst[ch] = d; m_cnt[ch] = n; m_mode[ch] = md;
  endtask

  task automatic fire(input logic [7:0] mask);
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        if (m_cnt[c] == 0 && !m_mode[c][2]) exp_irq[c]++;
        else order_q.push_back(c);
      end
    end
    @(negedge clk); trig = mask;
    @(negedge clk); trig = '0;
  endtask

  task automatic settle();
    int t = 0;
    while (order_q.size() != 0 && t < 3000) begin
      @(negedge clk); t++;
    end
    chk(t < 3000, "R9", "all pending served", t, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic verify(input string req);
    for (int c = 0; c < 8; c++) begin
      cfg_ch = 3'(c);
      cfg_sel = 2'd0; #1; chk(cfg_rdata == m_src[c], "R5", "source pointer", cfg_rdata, m_src[c]);
      cfg_sel = 2'd1; #1; chk(cfg_rdata == m_dst[c], "R5", "destination pointer", cfg_rdata, m_dst[c]);
      cfg_sel = 2'd2; #1; chk(cfg_rdata == {8'h0, m_cnt[c]}, "R6", "count", cfg_rdata, m_cnt[c]);
      cfg_sel = 2'd3; #1; chk(cfg_rdata == {13'h0, m_mode[c]}, "R2", "mode", cfg_rdata, m_mode[c]);
      chk(got_irq[c] == exp_irq[c], req, "forwarded pulses", got_irq[c], exp_irq[c]);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    for (int c = 0; c < 8; c++) begin
      m_src[c] = '0; m_dst[c] = '0; m_cnt[c] = '0; m_mode[c] = '0;
      exp_irq[c] = 0; got_irq[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mem_req == 1'b0, "R1", "no request after reset", mem_req, 0);
    chk(irq_fwd == 8'h00, "R1", "no forward after reset", irq_fwd, 0);
    verify("R1");

    // R2 R3 R4 R5 R6 R7: byte mode, source advances, count 3
    prog(2, 16'h1000, 16'h2000, 8'd3, 3'b000);
    verify("R2");
    for (int k = 0; k < 3; k++) begin
      fire(8'h04); settle();
    end
    verify("R7");
    chk(got_irq[2] == 1, "R7", "pulse when count ends", got_irq[2], 1);

    // R8: count already zero, forwarded with no access
    fire(8'h04); settle();
    verify("R8");
    chk(got_irq[2] == 2, "R8", "direct forward", got_irq[2], 2);

    // R5: word mode, destination advances and wraps
    prog(4, 16'h3000, 16'hfffe, 8'd2, 3'b011);
    fire(8'h10); settle();
    chk(m_dst[4] == 16'h0000, "R5", "model wrap", m_dst[4], 0);
    fire(8'h10); settle();
    verify("R5");

    // R11 R6: continuous mode with count zero still transfers, never forwards
    prog(6, 16'h5000, 16'h6000, 8'd0, 3'b101);
    fire(8'h40); settle();
    fire(8'h40); settle();
    verify("R11");
    chk(got_irq[6] == 0, "R11", "continuous never forwards", got_irq[6], 0);

    // R9 R10: all channels at once with a stalling ready line
    stall_on = 1;
    for (int c = 0; c < 8; c++)
      prog(c, 16'($urandom), 16'($urandom), 8'($urandom_range(1, 3)), 3'($urandom_range(0, 3)));
    fire(8'hff); settle();
    verify("R9");

    // R9: a trigger during a transfer waits even if lower-numbered
    prog(5, 16'h7000, 16'h7100, 8'd4, 3'b001);
    prog(1, 16'h7200, 16'h7300, 8'd4, 3'b000);
    fire(8'h20);
    fire(8'h02);
    settle();
    verify("R9");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      stall_on = bit'($urandom_range(0, 1));
      for (int c = 0; c < 8; c++)
        if ($urandom_range(0, 2) == 0)
          prog(c, 16'($urandom), 16'($urandom), 8'($urandom_range(0, 3)), 3'($urandom_range(0, 7)));
      fire(8'($urandom_range(1, 255))); settle();
      verify("R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule